// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a parallel flash device. Once software or another engine has written a program or erase command sequence to the flash, the poller takes over. It reads the target location again and again through a simple synchronous read port. From the status bits carried inside the returned data it decides whether the operation has finished cleanly, has failed, or is still in progress.

Two completion methods are available, chosen at each start.

- **Data polling** compares bit 7 of each read with the value the finished location will hold.
- **Toggle checking** compares every read with the read before it, and a settled device returns the same byte twice.

In both methods a set bit 5 on a read that is not yet complete marks a possible failure. The block confirms that with one more read before it judges. A poll limit set by a parameter bounds the whole sequence.

Top module: `flash_done_poller`

## Requirements
- R1: After reset `busy_o`, `done_ok_o`, `done_err_o` and `rd_req_o` are all low, and `rd_req_o` stays low whenever `busy_o` is low.
- R2: A `start_i` pulse seen while idle latches the address, operation and method, and `busy_o` is high from the next cycle. A `start_i` seen while busy has no effect on the running sequence: its address and operation are not used, and only one done pulse results.
- R3: Every read request carries the latched target address. Each `rd_req_o` is a one-cycle pulse, and no new request is made until `rd_valid_i` has returned the previous one.
- R4: With `mode_toggle_i`=0 (data polling), a read is complete when its bit 7 equals the expected bit. The expected bit is `exp_data_i[7]` for a program (`op_erase_i`=0) and 1 for an erase (`op_erase_i`=1). A complete read ends the sequence with `done_ok_o`, even if bit 5 of that read is set.
- R5: With `mode_toggle_i`=1 (toggle checking), the first read only serves as a reference. Every later read is complete when all 8 bits equal the read just before it.
- R6: A read that is not complete and has bit 5 set causes exactly one extra confirming read. The result is `done_ok_o` if that read passes the same completion test (in toggle mode, against the read that had bit 5 set) and `done_err_o` otherwise.
- R7: If `MAX_POLLS` ordinary reads pass without completion and without bit 5 set, the sequence ends with `done_err_o` and no further read is made.
- R8: `done_ok_o` and `done_err_o` are never high together, each lasts exactly one cycle, and `busy_o` is low in that cycle and afterwards until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a completion check (sampled while idle) |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| mode_toggle_i | input | 1 | 1 = toggle checking, 0 = data polling |
| addr_i | input | ADDR_W | Programmed address or address inside the erased sector |
| exp_data_i | input | 8 | Byte that was programmed |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data is valid |
| rd_data_i | input | 8 | Read data |
| busy_o | output | 1 | Sequence in progress |
| done_ok_o | output | 1 | One-cycle pulse: operation finished correctly |
| done_err_o | output | 1 | One-cycle pulse: operation failed or timed out |

## Verification
The in-module assertions check the following on every cycle:

- the done pulses are exclusive and one cycle long;
- requests are single pulses that never overlap an outstanding read;
- the read address holds steady while busy;
- no request appears while idle;
- the poll count never passes its limit.

Only the bench scenarios can show that the decision itself is right: which outcome each data sequence produces and after how many reads. The bench sweeps the number of busy reads across and past the poll limit in both methods, for program and erase and at several read latencies. It compares outcome and read count against values worked out from the rules above. It also covers the bit 5 confirmation paths and a start issued while busy.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    localparam int DATA_W  = 8;
    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;
    localparam int ERR_BIT  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ1,
        ST_READ2,
        ST_CHECK_ERR,
        ST_DONE_OK,
        ST_DONE_ERR
    } poll_state_e;

    typedef struct packed {
        logic toggle;
        logic exp7;
    } op_cfg_t;

    typedef struct packed {
        logic complete;
        logic err_seen;
    } verdict_t;

    function automatic logic target_bit(input logic erase, input logic [DATA_W-1:0] exp_byte);
        return erase ? 1'b1 : exp_byte[POLL_BIT];
    endfunction

    function automatic verdict_t judge(input op_cfg_t cfg,
                                       input logic [DATA_W-1:0] cur,
                                       input logic [DATA_W-1:0] prev);
        verdict_t v;
        v.complete = cfg.toggle ? (cur == prev) : (cur[POLL_BIT] == cfg.exp7);
        v.err_seen = cur[ERR_BIT];
        return v;
    endfunction

endpackage

// File: rtl/poll_rdport.sv
module poll_rdport (
    input  logic clk,
    input  logic rst,
    input  logic want_i,
    input  logic rd_valid_i,
    output logic rd_req_o,
    output logic resp_o
);
    logic pend_q;

    assign rd_req_o = want_i && !pend_q;
    assign resp_o   = rd_valid_i && pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (rd_req_o) begin
            pend_q <= 1'b1;
        end else if (resp_o) begin
            pend_q <= 1'b0;
        end
    end

    // R3: a request is never repeated in the cycle after it
    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |=> !rd_req_o);

endmodule

// File: rtl/poll_counter.sv
module poll_counter #(
    parameter int MAX_POLLS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [CNT_W-1:0] cnt_q;

    assign last_o = (cnt_q == CNT_W'(MAX_POLLS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7: the poll count never exceeds its limit
    p_poll_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(MAX_POLLS));

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_POLLS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic              mode_toggle_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] exp_data_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_ok_o,
    output logic              done_err_o
);
    poll_state_e       state_q, state_d;
    op_cfg_t           cfg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] prev_q;
    logic              want_rd, resp, last;
    logic              cnt_clr, cnt_inc;
    verdict_t          v;

    assign want_rd = (state_q == ST_READ1) || (state_q == ST_READ2) ||
                     (state_q == ST_CHECK_ERR);
    assign busy_o     = want_rd;
    assign done_ok_o  = (state_q == ST_DONE_OK);
    assign done_err_o = (state_q == ST_DONE_ERR);
    assign rd_addr_o  = addr_q;

    poll_rdport u_rdport (
        .clk        (clk),
        .rst        (rst),
        .want_i     (want_rd),
        .rd_valid_i (rd_valid_i),
        .rd_req_o   (rd_req_o),
        .resp_o     (resp)
    );

    poll_counter #(.MAX_POLLS(MAX_POLLS)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .last_o (last)
    );

    assign v = judge(cfg_q, rd_data_i, prev_q);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_READ1;
            end
            ST_READ1: begin
                if (resp) begin
                    if (cfg_q.toggle)   state_d = last ? ST_DONE_ERR : ST_READ2;
                    else if (v.complete) state_d = ST_DONE_OK;
                    else if (v.err_seen) state_d = ST_CHECK_ERR;
                    else if (last)       state_d = ST_DONE_ERR;
                end
            end
            ST_READ2: begin
                if (resp) begin
                    if (v.complete)      state_d = ST_DONE_OK;
                    else if (v.err_seen) state_d = ST_CHECK_ERR;
                    else if (last)       state_d = ST_DONE_ERR;
                end
            end
            ST_CHECK_ERR: begin
                if (resp) state_d = v.complete ? ST_DONE_OK : ST_DONE_ERR;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cnt_clr = (state_q == ST_IDLE) && start_i;
    assign cnt_inc = resp && ((state_d == ST_READ1) || (state_d == ST_READ2));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            addr_q  <= '0;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                cfg_q.toggle <= mode_toggle_i;
                cfg_q.exp7   <= target_bit(op_erase_i, exp_data_i);
                addr_q       <= addr_i;
            end
            if (resp) prev_q <= rd_data_i;
        end
    end

    // R8: outcomes are exclusive single-cycle pulses
    p_done_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(done_ok_o && done_err_o));
    p_ok_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_ok_o |=> !done_ok_o && !busy_o);
    p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_err_o |=> !done_err_o && !busy_o);
    // R1: no read request while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !rd_req_o);
    // R3: the target address holds for the whole sequence
    p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        busy_o && $past(busy_o) |-> $stable(rd_addr_o));
    // R2: a busy sequence ignores start and ends only through a done state
    p_busy_ends_in_done_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_ok_o || done_err_o);

endmodule

// File: tb/flash_done_poller_tb.sv
module flash_done_poller_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 16;
    localparam int MAXP = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0, op_erase_i = 1'b0, mode_toggle_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    exp_data_i = '0;
    logic          rd_req_o, rd_valid_i, busy_o, done_ok_o, done_err_o;
    logic [AW-1:0] rd_addr_o;
    logic [7:0]    rd_data_i;

    int checks = 0, fails = 0;
    int lat = 0;
    int rd_total = 0;
    int base_idx = 0;
    int addr_bad = 0, overlap_bad = 0;
    int cycles = 0;
    logic [AW-1:0] want_addr = '0;
    logic [7:0]    script [0:31];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_done_poller #(.ADDR_W(AW), .MAX_POLLS(MAXP)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .op_erase_i(op_erase_i),
        .mode_toggle_i(mode_toggle_i), .addr_i(addr_i), .exp_data_i(exp_data_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .done_ok_o(done_ok_o),
        .done_err_o(done_err_o)
    );

    // flash read model: answers each request after lat extra cycles
    logic       m_pend = 1'b0;
    int         m_cnt = 0;
    logic [7:0] m_hold = '0;
    always @(posedge clk) begin
        rd_valid_i <= 1'b0;
        if (rst) begin
            m_pend <= 1'b0;
            rd_data_i <= '0;
        end else if (rd_req_o) begin
            if (m_pend) overlap_bad <= overlap_bad + 1;
            if (rd_addr_o != want_addr) addr_bad <= addr_bad + 1;
            m_hold   <= script[(rd_total - base_idx) & 31];
            rd_total <= rd_total + 1;
            m_pend   <= 1'b1;
            m_cnt    <= lat;
        end else if (m_pend) begin
            if (m_cnt == 0) begin
                rd_valid_i <= 1'b1;
                rd_data_i  <= m_hold;
                m_pend     <= 1'b0;
            end else begin
                m_cnt <= m_cnt - 1;
            end
        end
    end

    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // runs one sequence; returns outcome (1=ok, 0=err) and read count
    task automatic run_op(input bit erase, input bit tog, input logic [AW-1:0] a,
                          input logic [7:0] ex, input bit restart_mid,
                          output int outcome, output int nreads);
        int guard = 0;
        int rd0;
        @(negedge clk);
        base_idx  = rd_total;
        rd0       = rd_total;
        want_addr = a;
        addr_bad  = 0;
        op_erase_i = erase; mode_toggle_i = tog; addr_i = a; exp_data_i = ex;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        outcome = -1;
        while (outcome < 0 && guard < 500) begin
            if (restart_mid && guard == 3) begin
                start_i = 1'b1; addr_i = a ^ 16'hFFFF; mode_toggle_i = ~tog;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            guard++;
            if (done_ok_o || done_err_o) begin
                check(!(done_ok_o && done_err_o), "R8 exclusive", done_ok_o, 0);
                check(!busy_o, "R8 busy low at done", busy_o, 0);
                outcome = done_ok_o ? 1 : 0;
            end
        end
        start_i = 1'b0;
        if (outcome < 0) begin
            check(0, "R8 done never seen", 0, 1);
            outcome = 2;
        end
        nreads = rd_total - rd0;
        @(negedge clk);
        check(!done_ok_o && !done_err_o && !busy_o, "R8 single-cycle done",
              done_ok_o | done_err_o | busy_o, 0);
        check(addr_bad == 0, "R3 read address", addr_bad, 0);
    endtask

    initial begin
        int oc, nr, exp_oc, exp_nr;
        logic e;
        fork
            begin
                repeat (150000) @(posedge clk);
                check(0, "R1 watchdog expired", cycles, 150000);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        join_none

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!busy_o && !done_ok_o && !done_err_o && !rd_req_o, "R1 reset state",
              {busy_o, done_ok_o, done_err_o, rd_req_o}, 0);

        // R4/R7 data polling sweep
        for (int l = 0; l < 3; l++) begin
            lat = l;
            for (int er = 0; er < 2; er++) begin
                for (int bv = 0; bv < 2; bv++) begin
                    for (int n = 0; n <= MAXP + 1; n++) begin
                        e = (er != 0) ? 1'b1 : bv[0];
                        for (int k = 0; k < 32; k++)
                            script[k] = (8'(k * 13) & 8'h5F) | {(k < n) ? ~e : e, 7'd0};
                        run_op(er[0], 1'b0, AW'(16'h1000 + n * 37 + l), {bv[0], 7'h2C},
                               1'b0, oc, nr);
                        exp_oc = (n < MAXP) ? 1 : 0;
                        exp_nr = (n < MAXP) ? n + 1 : MAXP;
                        check(oc == exp_oc, (n < MAXP) ? "R4 polling outcome" : "R7 polling timeout", oc, exp_oc);
                        check(nr == exp_nr, "R7 polling read count", nr, exp_nr);
                    end
                end
            end
        end

        // R5/R7 toggle sweep
        for (int l = 0; l < 3; l++) begin
            lat = l;
            for (int n = 0; n <= MAXP; n++) begin
                for (int k = 0; k < 32; k++)
                    script[k] = 8'h8A ^ ((((k < n) ? k : n) & 1) != 0 ? 8'h40 : 8'h00);
                run_op(1'b0, 1'b1, AW'(16'h2200 + n), 8'h55, 1'b0, oc, nr);
                exp_oc = (n + 2 <= MAXP) ? 1 : 0;
                exp_nr = (n + 2 <= MAXP) ? n + 2 : MAXP;
                check(oc == exp_oc, (exp_oc == 1) ? "R5 toggle outcome" : "R7 toggle timeout", oc, exp_oc);
                check(nr == exp_nr, "R5 toggle read count", nr, exp_nr);
            end
        end

        lat = 1;
        // R6 polling: bit 5 then passing confirm
        script[0] = 8'h20; script[1] = 8'h80;
        run_op(1'b0, 1'b0, 16'h3000, 8'h80, 1'b0, oc, nr);
        check(oc == 1, "R6 polling confirm ok", oc, 1);
        check(nr == 2, "R6 polling confirm reads", nr, 2);
        // R6 polling: bit 5 then failing confirm
        script[0] = 8'h20; script[1] = 8'h20;
        run_op(1'b1, 1'b0, 16'h3001, 8'h00, 1'b0, oc, nr);
        check(oc == 0, "R6 polling confirm err", oc, 0);
        check(nr == 2, "R6 polling err reads", nr, 2);
        // R4: complete read with bit 5 set is still ok
        script[0] = 8'hA0;
        run_op(1'b0, 1'b0, 16'h3002, 8'h80, 1'b0, oc, nr);
        check(oc == 1 && nr == 1, "R4 complete beats bit5", nr, 1);
        // R6 toggle: confirm equals flagged read
        script[0] = 8'h0A; script[1] = 8'h6A; script[2] = 8'h6A;
        run_op(1'b0, 1'b1, 16'h3003, 8'h00, 1'b0, oc, nr);
        check(oc == 1, "R6 toggle confirm ok", oc, 1);
        check(nr == 3, "R6 toggle confirm reads", nr, 3);
        script[2] = 8'h2A;
        run_op(1'b0, 1'b1, 16'h3004, 8'h00, 1'b0, oc, nr);
        check(oc == 0, "R6 toggle confirm err", oc, 0);
        check(nr == 3, "R6 toggle err reads", nr, 3);

        // R2: start while busy ignored (other address and method)
        lat = 2;
        for (int k = 0; k < 32; k++) script[k] = (k < 3) ? 8'h00 : 8'h80;
        run_op(1'b0, 1'b0, 16'h4444, 8'h80, 1'b1, oc, nr);
        check(oc == 1, "R2 restart ignored outcome", oc, 1);
        check(nr == 4, "R2 restart ignored reads", nr, 4);
        repeat (10) @(negedge clk);
        check(!busy_o, "R2 no second sequence", busy_o, 0);
        check(overlap_bad == 0, "R3 one outstanding read", overlap_bad, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule